// File: doc/BRIEF.md
# I/O Port Window Decoder

This block compares each host I/O port access against a small set of programmable port windows. A window covers a contiguous range of byte-granular ports. The range is given by a 16-bit first port and a 16-bit last port, and both ends are included. Each window has its own enable. It also has a four-bit control nibble that selects the wait-state controls and the effective data width. The width can follow the card's 16-bit chip-select indication, or it can be forced to 8 or 16 bits.

Configuration is written one byte at a time. Address 0 is a window-enable byte whose other bits belong to memory windows elsewhere. Address 1 is a control byte shared by the two I/O windows. Addresses 2 and 3 write one window's control nibble alone, so that software can update one window without read-modify-write. Each window then has four byte registers holding the low and high bytes of its first and last port. For every access the block reports, one cycle later, whether a window hit, which window it was, the resolved bus width and the wait-state controls. When no window hits, the block reports a miss and drives no card-side controls.

Top module: `io_window_decoder`

## Requirements
- R1: After reset every window is disabled and every control nibble and boundary is zero, so an access reports a miss and all decode outputs are low.
- R2: A window hits when it is enabled and first ≤ port ≤ last. Both ends of the range are included. `dec_win` reports the index of the window that hit.
- R3: A window whose enable bit is clear never hits. The enable for window w is bit 6+w of the byte at address 0. The other bits of that byte affect no decode output.
- R4: The boundaries of window w are at address 8+4w (first port, low byte), 9+4w (first port, high byte), 10+4w (last port, low byte) and 11+4w (last port, high byte). Writing one byte leaves the other three unchanged.
- R5: When both windows hit, window 0 wins.
- R6: An access that hits no window gives `dec_valid`=1 and `dec_hit`=0, with `dec_win`, `dec_bus16`, `dec_wait` and `dec_zws` all 0.
- R7: Control nibble bit 1 = 0 selects auto width. `dec_bus16` then equals the `card_iocs16` value sampled with the access.
- R8: Control nibble bit 1 = 1 forces the width. `dec_bus16` then equals nibble bit 0 (1 = 16-bit), whatever the value of `card_iocs16`.
- R9: On a hit, `dec_wait` equals the hitting window's nibble bit 3 and `dec_zws` equals its nibble bit 2.
- R10: The byte at address 1 holds window 0's nibble in bits 3:0 and window 1's nibble in bits 7:4. A write to address 2+w loads window w's nibble from data bits 3:0 and leaves the other window's nibble unchanged.
- R11: The decode outputs for an access appear exactly one clock after `acc_valid` is sampled high. A cycle without an access gives `dec_valid`=0 and `dec_hit`=0.
- R12: A window whose first port is greater than its last port never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration byte write strobe |
| wr_addr | input | 5 | Configuration byte address |
| wr_data | input | 8 | Configuration byte data |
| acc_valid | input | 1 | Host I/O access present this cycle |
| acc_port | input | 16 | Host I/O port address |
| card_iocs16 | input | 1 | Card's 16-bit chip-select indication |
| dec_valid | output | 1 | Registered access-present flag |
| dec_hit | output | 1 | Some window matched the access |
| dec_win | output | 1 | Index of the matching window |
| dec_bus16 | output | 1 | Effective bus width is 16 bits |
| dec_wait | output | 1 | Extra wait state requested |
| dec_zws | output | 1 | Zero-wait-state cycle requested |

## Verification
A configuration write made at one clock edge governs accesses sampled at the next edge. Every decode output belonging to an access is due exactly one edge after the access is sampled. The bench drives a new access on every falling edge and compares all six decode outputs on the following falling edge, so each comparison covers exactly one access. Expected results come from a shadow copy of the register map that the bench's write task keeps up to date. This lets back-to-back accesses stream at full rate, with a full 65536-port sweep in one configuration. The sweep tests the one-cycle latency on every port as well as the decode itself.

// File: rtl/io_window_decoder.sv
module io_window_decoder #(
  parameter int NWIN     = 2,
  parameter int RA_W     = 5,
  parameter int EN_BASE  = 6,
  parameter int WIN_BASE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            acc_valid,
  input  logic [15:0]     acc_port,
  input  logic            card_iocs16,
  output logic            dec_valid,
  output logic            dec_hit,
  output logic [(NWIN>1 ? $clog2(NWIN) : 1)-1:0] dec_win,
  output logic            dec_bus16,
  output logic            dec_wait,
  output logic            dec_zws
);
  localparam int WW        = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int A_ENABLE  = 0;
  localparam int A_CTLBYTE = 1;
  localparam int A_CTLNIB  = 2;

  logic [15:0]     win_first [NWIN];
  logic [15:0]     win_last  [NWIN];
  logic            win_en    [NWIN];
  logic [3:0]      win_ctl   [NWIN];
  logic [NWIN-1:0] in_rng;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int BASE = WIN_BASE + 4 * w;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_first[w] <= '0;
        win_last[w]  <= '0;
        win_en[w]    <= 1'b0;
        win_ctl[w]   <= '0;
      end else if (wr_en) begin
        if (wr_addr == RA_W'(A_ENABLE))   win_en[w]         <= wr_data[EN_BASE + w];
        if (wr_addr == RA_W'(A_CTLNIB+w)) win_ctl[w]        <= wr_data[3:0];
        if (w < 2 && wr_addr == RA_W'(A_CTLBYTE))
                                          win_ctl[w]        <= wr_data[(4*w)%8 +: 4];
        if (wr_addr == RA_W'(BASE))       win_first[w][7:0]  <= wr_data;
        if (wr_addr == RA_W'(BASE + 1))   win_first[w][15:8] <= wr_data;
        if (wr_addr == RA_W'(BASE + 2))   win_last[w][7:0]   <= wr_data;
        if (wr_addr == RA_W'(BASE + 3))   win_last[w][15:8]  <= wr_data;
      end
    end

    assign in_rng[w] = win_en[w] && (acc_port >= win_first[w]) && (acc_port <= win_last[w]);
  end

  logic          sel;
  logic [WW-1:0] sel_idx;
  logic [3:0]    sel_ctl;

  always_comb begin
    sel     = 1'b0;
    sel_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        sel     = 1'b1;
        sel_idx = WW'(i);
      end
    end
  end

  assign sel_ctl = sel ? win_ctl[sel_idx] : 4'h0;

  wire take   = acc_valid && sel;
  wire width  = sel_ctl[1] ? sel_ctl[0] : card_iocs16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_hit   <= 1'b0;
      dec_win   <= '0;
      dec_bus16 <= 1'b0;
      dec_wait  <= 1'b0;
      dec_zws   <= 1'b0;
    end else begin
      dec_valid <= acc_valid;
      dec_hit   <= take;
      dec_win   <= take ? sel_idx : '0;
      dec_bus16 <= take && width;
      dec_wait  <= take && sel_ctl[3];
      dec_zws   <= take && sel_ctl[2];
    end
  end
endmodule

module io_window_decoder_chk #(
  parameter int WW = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          dec_valid,
  input logic          dec_hit,
  input logic [WW-1:0] dec_win,
  input logic          dec_bus16,
  input logic          dec_wait,
  input logic          dec_zws
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) acc_valid |=> dec_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |=> (!dec_valid && !dec_hit)); // R11
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) dec_hit |-> dec_valid); // R11
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_hit) |-> (!dec_bus16 && !dec_wait && !dec_zws && dec_win == '0)); // R6
endmodule

bind io_window_decoder io_window_decoder_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .dec_valid(dec_valid),
  .dec_hit(dec_hit), .dec_win(dec_win), .dec_bus16(dec_bus16),
  .dec_wait(dec_wait), .dec_zws(dec_zws)
);

// File: tb/test_io_window_decoder.sv
module test_io_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_port = '0;
  logic        card_iocs16 = 1'b0;
  logic        dec_valid, dec_hit, dec_bus16, dec_wait, dec_zws;
  logic [0:0]  dec_win;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] sh_first [2];
  logic [15:0] sh_last  [2];
  logic        sh_en    [2];
  logic [3:0]  sh_ctl   [2];

  always #4 clk = ~clk;

  io_window_decoder i_io_window_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_valid(acc_valid), .acc_port(acc_port), .card_iocs16(card_iocs16),
    .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_win(dec_win),
    .dec_bus16(dec_bus16), .dec_wait(dec_wait), .dec_zws(dec_zws)
  );

  function automatic logic [5:0] model(input logic v, input logic [15:0] p, input logic cs);
    logic h = 1'b0;
    logic wi = 1'b0;
    logic [3:0] c = 4'h0;
    if (v)
      for (int w = 1; w >= 0; w--)
        if (sh_en[w] && p >= sh_first[w] && p <= sh_last[w]) begin
          h = 1'b1;
          wi = w[0];
        end
    if (h) c = sh_ctl[wi];
    return {v, h, h & wi, h & (c[1] ? c[0] : cs), h & c[3], h & c[2]};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    logic [5:0] got = {dec_valid, dec_hit, dec_win, dec_bus16, dec_wait, dec_zws};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port=%h: got %b expected %b (valid,hit,win,bus16,wait,zws)",
               tag, acc_port, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 5'd0) begin
      sh_en[0] = d[6]; sh_en[1] = d[7];
    end else if (a == 5'd1) begin
      sh_ctl[0] = d[3:0]; sh_ctl[1] = d[7:4];
    end else if (a == 5'd2 || a == 5'd3) begin
      sh_ctl[a - 5'd2] = d[3:0];
    end else if (a >= 5'd8 && a < 5'd16) begin
      int w = (int'(a) - 8) / 4;
      case ((int'(a) - 8) % 4)
        0: sh_first[w][7:0]  = d;
        1: sh_first[w][15:8] = d;
        2: sh_last[w][7:0]   = d;
        default: sh_last[w][15:8] = d;
      endcase
    end
  endtask

  task automatic acc(input string tag, input logic v, input logic [15:0] p, input logic cs);
    logic [5:0] exp = model(v, p, cs);
    acc_valid = v; acc_port = p; card_iocs16 = cs;
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic set_win(input logic [4:0] w, input logic [15:0] f, input logic [15:0] l);
    wr(5'd8 + 5'd4 * w, f[7:0]);
    wr(5'd9 + 5'd4 * w, f[15:8]);
    wr(5'd10 + 5'd4 * w, l[7:0]);
    wr(5'd11 + 5'd4 * w, l[15:8]);
  endtask

  initial begin
    for (int w = 0; w < 2; w++) begin
      sh_first[w] = '0; sh_last[w] = '0; sh_en[w] = 1'b0; sh_ctl[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset outputs", 6'b000000);
    acc("R1 reset miss", 1'b1, 16'h0000, 1'b1);
    acc("R1 reset miss", 1'b1, 16'h1234, 1'b1);

    // R2 R5 R7 R8: overlapping windows, full port sweep
    set_win(5'd0, 16'h0100, 16'h011F);
    set_win(5'd1, 16'h0110, 16'h0200);
    wr(5'd1, 8'h30);
    wr(5'd0, 8'hC0);
    for (int p = 0; p < 65536; p++)
      acc("R2 R5 R6 R7 R8 sweep", 1'b1, 16'(p), p[3] ^ p[0]);

    // R11 idle cycles between accesses
    acc("R11 idle", 1'b0, 16'h0105, 1'b1);
    acc("R11 access", 1'b1, 16'h0105, 1'b1);
    acc("R11 idle", 1'b0, 16'h0150, 1'b0);

    // R3 enable gating, memory-window bits ignored
    wr(5'd0, 8'h9F);
    for (int p = 16'h00F0; p < 16'h0210; p++)
      acc("R3 window0 disabled", 1'b1, 16'(p), p[1]);
    wr(5'd0, 8'h3F);
    for (int p = 16'h0100; p < 16'h0110; p++)
      acc("R3 both disabled", 1'b1, 16'(p), 1'b1);
    wr(5'd0, 8'hC0);

    // R10 nibble writes leave the other window alone; R9 wait bits
    wr(5'd2, 8'hF4);
    for (int p = 16'h0118; p < 16'h0124; p++)
      acc("R10 R9 window0 nibble", 1'b1, 16'(p), 1'b0);
    wr(5'd3, 8'h0A);
    for (int p = 16'h0118; p < 16'h0124; p++)
      acc("R10 R8 forced 8-bit", 1'b1, 16'(p), 1'b1);
    wr(5'd1, 8'h7C);
    for (int p = 16'h0118; p < 16'h0124; p++)
      acc("R10 R9 full control byte", 1'b1, 16'(p), p[0]);

    // R2 boundaries at both ends of the port space
    set_win(5'd0, 16'hFFFF, 16'hFFFF);
    set_win(5'd1, 16'h0000, 16'h0000);
    acc("R2 top edge", 1'b1, 16'hFFFE, 1'b1);
    acc("R2 top edge", 1'b1, 16'hFFFF, 1'b1);
    acc("R2 bottom edge", 1'b1, 16'h0000, 1'b0);
    acc("R2 bottom edge", 1'b1, 16'h0001, 1'b0);

    // R4 single byte rewrites
    wr(5'd14, 8'h00);
    wr(5'd15, 8'h03);
    for (int p = 16'h02FC; p < 16'h0304; p++)
      acc("R4 last high byte only", 1'b1, 16'(p), 1'b1);
    wr(5'd13, 8'h02);
    for (int p = 16'h01FC; p < 16'h0204; p++)
      acc("R4 first high byte only", 1'b1, 16'(p), 1'b1);

    // R12 inverted window
    set_win(5'd0, 16'h0500, 16'h04FF);
    set_win(5'd1, 16'h0600, 16'h0600);
    for (int p = 16'h04F0; p < 16'h0510; p++)
      acc("R12 inverted", 1'b1, 16'(p), 1'b1);

    acc("R11 final idle", 1'b0, 16'h0000, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog: got still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule